// File: doc/BRIEF.md
# Token-Driven I2C Master Sequencer

This block is an I2C master that carries out a short program of 4-bit command tokens. Software loads the program, a target address and up to eight bytes of outgoing data into registers, then sets a start bit. The sequencer steps through the tokens one by one. Depending on the token, it places a START or STOP condition on the bus, sends the address byte with a direction bit, sends a data byte from the write window, or receives a byte into the read window and answers it with ACK or NACK. While the program runs a busy flag is set. A target that refuses a byte raises an error flag, unless software asked for acknowledges to be ignored.

Bus timing comes from an external divider through a single-cycle `tick` input, and each tick moves the engine one quarter of an SCL bit. Both lines are open-drain: an output of 1 pulls the line low. A program that ends without a STOP leaves SCL held low, so the next program can continue the same transaction with a repeated START.

Top module: `i2c_token_master`

## Requirements
- R1: After reset, every register word (offsets 0 to 7) reads zero, and both `scl_oe` and `sda_oe` are 0, so both lines are released.
- R2: Writing offset 0 with bit 0 set launches the program, but only if bit 0 was previously 0 and the engine is idle. A launch sets busy (bit 2), clears error (bit 3) and zeroes the read window. Writing bit 0 as 1 again while it is still 1 launches nothing.
- R3: Token i sits in bits 4i+3:4i of the 64-bit value {offset 3, offset 2}. Tokens run in ascending order of i.
- R4: Codes are 0 end, 1 start, 2 address-write, 3 address-read, 4 data, 5 data-last, 6 stop. Code 0 or any code from 7 to 15 ends the program and clears busy, as does completing token 15. No later token affects the bus.
- R5: A start token produces a START condition (SDA falls while SCL is high), including a repeated START from a held bus. A stop token produces a STOP condition and leaves both lines released.
- R6: An address token sends bits 7:1 of offset 1, MSB first, followed by a direction bit: 0 for code 2, 1 for code 3.
- R7: After an address-write, the n-th data token (counting from 0 within the program) sends byte n of the write window. Byte k lies in bits 8(k mod 4)+7:8(k mod 4) of offset 4 for k<4 and of offset 5 for k>=4.
- R8: After an address-read, code 4 answers the received byte with ACK and code 5 answers it with NACK. The n-th data token stores its byte as byte n of the read window (offsets 6 and 7, same packing as R7).
- R9: If SDA is high in the acknowledge slot of an address or written byte and ignore-ACK (bit 1) is 0, the error flag sets, busy clears and no further token is executed.
- R10: With ignore-ACK set at launch, a refused byte neither sets the error flag nor stops the program.
- R11: A program that ends without a stop token leaves SCL held low.
- R12: Each bit of a byte takes four ticks, with rising SCL edges one bit period apart. Inside a byte, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tick | input | 1 | Quarter-bit timing pulse from the SCL divider |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest cases to reach from the ports are the ones decided by the far end of the bus. These are a refusal in the middle of a write burst, a refused address, and a program that stops with the bus held, followed by a repeated START from another program. The bench drives the lines through a behavioural target. The target answers to one address, refuses a chosen write byte and serves a computed read pattern. Every START, STOP, byte and master acknowledge it decodes is compared against the sequence that the token list predicts. Follow-up programs that contain only a STOP show that an aborted or held transfer can be resumed cleanly.

// File: rtl/i2c_token_master.sv
`timescale 1ns/1ps
module i2c_token_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tick,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);

  localparam int NTOK  = 16;
  localparam int NBYTE = 8;
  localparam int TIW   = $clog2(NTOK) + 1;
  localparam int BIW   = $clog2(NBYTE);
  localparam logic [3:0] T_START = 4'd1, T_AW = 4'd2, T_AR = 4'd3,
                         T_DATA = 4'd4, T_LAST = 4'd5, T_STOP = 4'd6;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_BYTE, S_STOP} st_t;

  st_t st;
  logic go, ign, busy, err, ign_run;
  logic [7:0] tgt;
  logic [NTOK*4-1:0] tok_q;
  logic [NBYTE*8-1:0] wwin, rwin;
  logic [TIW-1:0] tix;
  logic [BIW-1:0] dix;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic rd_mode, rd_byte, is_data, nack_me, nak, scl_q, sda_q;
  logic [3:0] cur;
  logic launch, at_end;

  assign cur    = tok_q[{tix[TIW-2:0], 2'b00} +: 4];
  assign at_end = tix[TIW-1];
  assign launch = reg_we && reg_addr == 3'd0 && reg_wdata[0] && !go && !busy;
  assign scl_oe = ~scl_q;
  assign sda_oe = ~sda_q;

  always_comb begin
    case (reg_addr)
      3'd0:       reg_rdata = {28'd0, err, busy, ign, go};
      3'd1:       reg_rdata = {24'd0, tgt};
      3'd2, 3'd3: reg_rdata = tok_q[{reg_addr[0], 5'd0} +: 32];
      3'd4, 3'd5: reg_rdata = wwin[{reg_addr[0], 5'd0} +: 32];
      default:    reg_rdata = rwin[{reg_addr[0], 5'd0} +: 32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; ign <= 1'b0; tgt <= '0; tok_q <= '0; wwin <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: begin
          go <= reg_wdata[0];
          if (!busy) ign <= reg_wdata[1];
        end
        3'd1:       tgt <= reg_wdata[7:0];
        3'd2, 3'd3: tok_q[{reg_addr[0], 5'd0} +: 32] <= reg_wdata;
        3'd4, 3'd5: wwin[{reg_addr[0], 5'd0} +: 32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; err <= 1'b0; ign_run <= 1'b0; rwin <= '0;
      tix <= '0; dix <= '0; ph <= '0; bitn <= '0; sh <= '0;
      rd_mode <= 1'b0; rd_byte <= 1'b0; is_data <= 1'b0; nack_me <= 1'b0; nak <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else if (launch) begin
      busy <= 1'b1; err <= 1'b0; ign_run <= reg_wdata[1]; rwin <= '0;
      tix <= '0; dix <= '0; st <= S_FETCH;
    end else begin
      case (st)
        S_FETCH: begin
          ph <= '0; bitn <= '0; nak <= 1'b0;
          if (at_end) begin
            busy <= 1'b0; st <= S_IDLE;
          end else begin
            tix <= tix + 1'b1;
            case (cur)
              T_START: st <= S_START;
              T_STOP:  st <= S_STOP;
              T_AW, T_AR: begin
                sh <= {tgt[7:1], cur[0]};
                rd_mode <= cur[0]; rd_byte <= 1'b0; is_data <= 1'b0;
                st <= S_BYTE;
              end
              T_DATA, T_LAST: begin
                sh <= rd_mode ? 8'hFF : wwin[{dix, 3'b000} +: 8];
                rd_byte <= rd_mode; is_data <= 1'b1; nack_me <= cur[0];
                st <= S_BYTE;
              end
              default: begin busy <= 1'b0; st <= S_IDLE; end
            endcase
          end
        end
        S_START, S_STOP: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_q <= (st == S_START);
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= (st == S_STOP);
            default: begin
              if (st == S_START) scl_q <= 1'b0;
              st <= S_FETCH;
            end
          endcase
        end
        S_BYTE: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_q <= bitn[3] ? (rd_byte ? nack_me : 1'b1) : sh[7];
            2'd1: scl_q <= 1'b1;
            2'd2: begin
              if (!bitn[3]) sh <= {sh[6:0], sda_in};
              else nak <= !rd_byte && sda_in && !ign_run;
            end
            default: begin
              scl_q <= 1'b0;
              if (!bitn[3]) bitn <= bitn + 1'b1;
              else if (nak) begin
                err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
              end else begin
                if (is_data) dix <= dix + 1'b1;
                if (rd_byte) rwin[{dix, 3'b000} +: 8] <= sh;
                st <= S_FETCH;
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && !err);
  a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && st == S_IDLE);
  a_r10_ignore_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ign_run) |=> !$rose(err));
  a_r12_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && scl_q && $past(scl_q)) |-> $stable(sda_q));
  a_r5_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && tick && ph == 2'd3) |=> scl_q && sda_q);
  a_r4_limit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && at_end) |=> !busy);

endmodule

// File: tb/tb_i2c_token_master.sv
`timescale 1ns/1ps
module tb_i2c_token_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, tick = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe, tgt_pull = 1'b0;
  logic scl, sda;
  logic [1:0] tcnt = '0;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | tgt_pull);

  always #2.5 clk = ~clk;
  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd2);
  end

  i2c_token_master dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
  );

  localparam logic [6:0] TGT = 7'h2A;
  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  function void check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endfunction

  function void push(int kind, int val, string tag);
    exp_q.push_back(kind * 256 + val);
    tag_q.push_back(tag);
  endfunction

  function void observe(int kind, int val);
    int got;
    got = kind * 256 + val;
    if (exp_q.size() == 0) check(0, "R4 extra bus event", got, 0);
    else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(got == e, t, got, e);
    end
  endfunction

  function logic [7:0] rpat(int k);
    return 8'h3C + 8'(k * 29);
  endfunction

  // bus decoder and behavioural target
  logic ps = 1'b1, pd = 1'b1;
  int bitn = 0, wcnt = 0, rcnt = 0, nack_at = -1, cyc = 0, last_rise = 0, per = 0;
  bit is_addr = 0, reading = 0, active = 0, nacked = 0, inbyte = 0;
  logic [7:0] sh = '0, tx = '0;

  always @(negedge clk) begin
    logic s, d;
    s = scl; d = sda; cyc++;
    if (ps && s && pd && !d) begin
      observe(1, 0);
      bitn = 0; is_addr = 1; reading = 0; active = 0; nacked = 0;
      inbyte = 1; wcnt = 0; rcnt = 0; tgt_pull = 0;
    end else if (ps && s && !pd && d) begin
      observe(2, 0);
      inbyte = 0; tgt_pull = 0;
    end else if (!ps && s) begin
      per = cyc - last_rise; last_rise = cyc;
      if (inbyte) begin
        if (bitn < 8) sh = {sh[6:0], d};
        else if (bitn == 8 && reading && !is_addr) begin
          observe(4, int'(!d));
          if (d) nacked = 1;
        end
        bitn++;
      end
    end else if (inbyte && ps && !s) begin
      if (bitn == 8) begin
        if (is_addr || !reading) begin
          observe(3, int'(sh));
          if (is_addr) begin
            active = (sh[7:1] == TGT); reading = active && sh[0]; tgt_pull = active;
          end else begin
            tgt_pull = active && (wcnt != nack_at); wcnt++;
          end
        end else tgt_pull = 0;
      end else if (bitn == 9) begin
        bitn = 0; is_addr = 0;
        if (reading && !nacked) begin
          tx = rpat(rcnt); rcnt++; tgt_pull = !tx[7];
        end else tgt_pull = 0;
      end else if (bitn < 8 && reading && !is_addr) tgt_pull = !tx[7 - bitn];
    end
    ps = s; pd = d;
  end

  // driver
  logic [63:0] tl;
  int nt = 0, bn = 0;
  bit brd = 0;
  logic [6:0] cur_addr = TGT;
  logic [7:0] wb [8];

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tok_clear();
    tl = '0; nt = 0; bn = 0;
  endtask

  task automatic tok(input int t, input bit e);
    tl[nt*4 +: 4] = 4'(t); nt++;
    case (t)
      1: if (e) push(1, 0, "R5 start condition");
      2: begin brd = 0; if (e) push(3, {cur_addr, 1'b0}, "R6 write address"); end
      3: begin brd = 1; if (e) push(3, {cur_addr, 1'b1}, "R6 read address"); end
      4, 5: begin
        if (e) begin
          if (brd) push(4, (t == 4) ? 1 : 0, "R8 master ack/nack");
          else push(3, wb[bn], "R7 write byte");
        end
        bn++;
      end
      6: if (e) push(2, 0, "R5 stop condition");
      default: ;
    endcase
  endtask

  task automatic run(input bit ign, input bit clr);
    logic [31:0] v;
    int n;
    wr(3'd1, {24'd0, cur_addr, 1'b0});
    wr(3'd2, tl[31:0]);
    wr(3'd3, tl[63:32]);
    wr(3'd4, {wb[3], wb[2], wb[1], wb[0]});
    wr(3'd5, {wb[7], wb[6], wb[5], wb[4]});
    wr(3'd0, {30'd0, ign, 1'b1});
    rd(3'd0, v);
    check(v[2] == 1'b1, "R2 busy after launch", int'(v[2]), 1);
    if (clr) wr(3'd0, {30'd0, ign, 1'b0});
    n = 0;
    do begin rd(3'd0, v); n++; end while (v[2] && n < 20000);
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R3 all listed events in order", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic ctl_check(input int bitpos, input bit expv, input string tag);
    logic [31:0] v;
    rd(3'd0, v);
    check(v[bitpos] == expv, tag, int'(v[bitpos]), int'(expv));
  endtask

  task automatic stop_only();
    tok_clear(); tok(6, 1); run(0, 1);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wb[i] = 8'(8'h11 * (i + 1));
    repeat (4) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 32'd0, "R1 register reset value", v, 0);
    end
    check(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);

    // plain write
    tok_clear(); tok(1,1); tok(2,1); tok(4,1); tok(4,1); tok(4,1); tok(6,1);
    run(0, 1);
    ctl_check(3, 0, "R9 no error on acked write");
    check(scl_oe == 0 && sda_oe == 0, "R5 bus free after stop", {scl_oe, sda_oe}, 0);
    check(per == 16, "R12 bit period of four ticks", per, 16);

    // read of five bytes
    tok_clear(); tok(1,1); tok(3,1); tok(4,1); tok(4,1); tok(4,1); tok(4,1); tok(5,1); tok(6,1);
    run(0, 1);
    rd(3'd6, v);
    check(v == {rpat(3), rpat(2), rpat(1), rpat(0)}, "R8 read window low word", v, {rpat(3), rpat(2), rpat(1), rpat(0)});
    rd(3'd7, v);
    check(v == {24'd0, rpat(4)}, "R8 read window high word", v, {24'd0, rpat(4)});

    // held bus then repeated start
    tok_clear(); tok(1,1); tok(2,1); tok(4,1);
    run(0, 1);
    check(scl_oe == 1, "R11 SCL held after list without stop", scl_oe, 1);
    tok_clear(); tok(1,1); tok(3,1); tok(5,1); tok(6,1);
    run(0, 1);
    rd(3'd6, v);
    check(v == {24'd0, rpat(0)}, "R8 first data token fills byte 0", v, {24'd0, rpat(0)});
    rd(3'd7, v);
    check(v == 32'd0, "R2 read window cleared at launch", v, 0);

    // refused second write byte
    nack_at = 1;
    tok_clear(); tok(1,1); tok(2,1); tok(4,1); tok(4,1); tok(4,0); tok(6,0);
    run(0, 1);
    nack_at = -1;
    ctl_check(3, 1, "R9 error on refused write byte");
    ctl_check(2, 0, "R9 busy cleared on error");
    stop_only();
    ctl_check(3, 0, "R2 error cleared by launch");

    // refused address with ignore-ACK
    cur_addr = 7'h11;
    tok_clear(); tok(1,1); tok(2,1); tok(4,1); tok(4,1); tok(6,1);
    run(1, 1);
    ctl_check(3, 0, "R10 ignore-ACK keeps error clear");

    // refused address without ignore-ACK
    tok_clear(); tok(1,1); tok(2,1); tok(4,0); tok(6,0);
    run(0, 1);
    ctl_check(3, 1, "R9 error on refused address");
    stop_only();
    cur_addr = TGT;

    // sixteen tokens, no end code
    tok_clear();
    tok(1,1); tok(2,1); for (int i = 0; i < 6; i++) tok(4,1);
    tok(1,1); tok(2,1); tok(4,1); tok(4,1);
    tok(1,1); tok(2,1); tok(1,1); tok(6,1);
    run(0, 1);
    ctl_check(3, 0, "R4 full list completes");
    check(scl_oe == 0 && sda_oe == 0, "R4 bus free after 16th token", {scl_oe, sda_oe}, 0);

    // end code mid-list
    tok_clear(); tok(1,1); tok(2,1); tok(0,0); tok(4,0); tok(6,0);
    run(0, 1);
    check(scl_oe == 1, "R4 end code halts with bus held", scl_oe, 1);
    stop_only();

    // unused code mid-list
    tok_clear(); tok(1,1); tok(2,1); tok(11,0); tok(4,0); tok(6,0);
    run(0, 1);
    check(scl_oe == 1, "R4 unused code halts", scl_oe, 1);
    stop_only();

    // start bit left set: no relaunch
    tok_clear(); tok(1,1); tok(6,1);
    run(0, 0);
    wr(3'd0, 32'd1);
    ctl_check(2, 0, "R2 no relaunch while start held");
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R2 no bus activity without relaunch", exp_q.size(), 0);
    wr(3'd0, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(0, "R1 watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule